// File: doc/BRIEF.md
# FPU status flag accumulator

This block sits beside a floating-point datapath and turns the per-operation status vector that the datapath reports into sticky flag bits inside a floating-point control/status register. Several distinct invalid-operation causes fold into one shared invalid flag, and the infinity-arithmetic causes also feed a separate infinity flag. Accumulation only happens while the enable bit in the same register is set.

After every accepted status report, the block looks at the eight flags as they stand after the update. Flags left over from earlier operations count as well. If any flag is set, it issues a one-cycle exception request. The request carries the previous-instruction PC that came with the report, and the trap logic uses that PC as the faulting address. Software clears flags, and changes the enable bit, by writing the whole register through the write port.

Top module: `fpflag_accum`

## Requirements
- R1: After synchronous reset, `csr_q` is all zero, `fpe_req` is 0 and `fpe_pc` is 0.
- R2: When `csr_we` is 1 at a clock edge, `csr_q` equals `csr_wdata` after that edge. All bits are replaced, so this is how flags are cleared.
- R3: When `csr_we` and `st_valid` are both 1 in one cycle, the status report is discarded. `csr_q` takes `csr_wdata` and `fpe_req` stays 0 in the next cycle.
- R4: `csr_q` bit 0 is the enable bit. A status report that arrives while bit 0 is 0 leaves `csr_q` unchanged and raises no request.
- R5: `csr_q` bit 1 (invalid) is set by any of the nine invalid causes. These are `st_bits` bits 0 to 8: signalling NaN 0, quiet NaN 1, inf-minus-inf 2, inf-div-inf 3, zero-div-zero 4, inf-times-zero 5, convert 6, compare 7, square root 8.
- R6: `csr_q` bit 2 is set by a signalling NaN (`st_bits` bit 0). `csr_q` bit 3 is set by a quiet NaN (`st_bits` bit 1).
- R7: `st_bits` bit 9 (overflow) sets `csr_q` bit 4. Bit 10 (underflow) sets `csr_q` bit 5. Bit 11 (divide-by-zero) sets `csr_q` bit 7. Bit 12 (inexact) sets `csr_q` bit 8.
- R8: `csr_q` bit 6 (infinity) is set only by `st_bits` bit 2 or bit 3.
- R9: The flags in `csr_q` bits 1 to 8 are sticky, and only a write clears them. A status report never changes bit 0 or any bit above bit 8.
- R10: One cycle after an accepted report, `fpe_req` is 1 for exactly that cycle if any of `csr_q` bits 1 to 8 is set after the update. Otherwise it is 0.
- R11: Whenever `fpe_req` is 1, `fpe_pc` equals the `st_ppc` value that came with the report. `fpe_pc` changes only on an accepted report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | CSR_W | Register write value |
| st_valid | input | 1 | Status report strobe |
| st_bits | input | 13 | Per-operation status causes |
| st_ppc | input | PC_W | Previous-instruction PC of the reporting operation |
| csr_q | output | CSR_W | Control/status register value |
| fpe_req | output | 1 | Floating-point exception request pulse |
| fpe_pc | output | PC_W | Faulting address for the request |

## Verification
The bench builds the block with CSR_W = 12 and PC_W = 16. The three register bits above the flags can then be seeded with known values, so any disturbance to them by a status report shows up. Because there are only 13 status causes, all 8192 status patterns can be swept, once with the enable bit set and once with it clear, and each result is compared with a flag mapping the bench derives from the requirements. Directed sequences add stale-flag requests, clearing by writes, a write colliding with a report, and step-by-step accumulation of single causes.

// File: rtl/fpflag_pkg.sv
package fpflag_pkg;
  // status vector cause positions
  localparam int NST     = 13;
  localparam int ST_SNAN = 0;
  localparam int ST_QNAN = 1;
  localparam int ST_ISI  = 2;
  localparam int ST_IDI  = 3;
  localparam int ST_SQRT = 8;
  localparam int ST_OVF  = 9;
  localparam int ST_UNF  = 10;
  localparam int ST_DZ   = 11;
  localparam int ST_IX   = 12;

  // register layout
  localparam int CSR_EN  = 0;
  localparam int FLAG_LO = 1;
  localparam int NFLAG   = 8;
  localparam int CSR_INF = 6;

  typedef struct packed {
    logic ix;
    logic dz;
    logic inf;
    logic unf;
    logic ovf;
    logic qnf;
    logic snf;
    logic ivf;
  } flags_t;
endpackage

// File: rtl/fpflag_map.sv
module fpflag_map
  import fpflag_pkg::*;
(
  input  logic [NST-1:0]   st_i,
  output logic [NFLAG-1:0] set_o
);
  flags_t f;

  always_comb begin
    f     = '0;
    f.ivf = |st_i[ST_SQRT:ST_SNAN];
    f.snf = st_i[ST_SNAN];
    f.qnf = st_i[ST_QNAN];
    f.ovf = st_i[ST_OVF];
    f.unf = st_i[ST_UNF];
    f.inf = st_i[ST_ISI] | st_i[ST_IDI];
    f.dz  = st_i[ST_DZ];
    f.ix  = st_i[ST_IX];
    set_o = f;
  end
endmodule

// File: rtl/fpflag_csr.sv
module fpflag_csr
  import fpflag_pkg::*;
#(
  parameter int CSR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CSR_W-1:0] wdata,
  input  logic             accept,
  input  logic [NFLAG-1:0] set,
  output logic [CSR_W-1:0] csr_q,
  output logic [NFLAG-1:0] flags_next
);
  for (genvar b = 0; b < CSR_W; b++) begin : g_bit
    if (b >= FLAG_LO && b < FLAG_LO + NFLAG) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)                             csr_q[b] <= 1'b0;
        else if (we)                         csr_q[b] <= wdata[b];
        else if (accept && set[b - FLAG_LO]) csr_q[b] <= 1'b1;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)     csr_q[b] <= 1'b0;
        else if (we) csr_q[b] <= wdata[b];
      end
    end
  end

  assign flags_next = csr_q[FLAG_LO +: NFLAG] | (accept ? set : '0);

  // R2: a write replaces the whole register
  p_write_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> (csr_q == $past(wdata)));

  // R9: without a write no bit is ever cleared
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !we |=> ((csr_q & $past(csr_q)) == $past(csr_q)));

  // R9: without a write the enable bit holds
  p_en_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !we |=> (csr_q[CSR_EN] == $past(csr_q[CSR_EN])));
endmodule

// File: rtl/fpflag_exc.sv
module fpflag_exc
  import fpflag_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [NFLAG-1:0] flags_next,
  input  logic [PC_W-1:0]  ppc,
  output logic             req_o,
  output logic [PC_W-1:0]  pc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= 1'b0;
      pc_o  <= '0;
    end else begin
      req_o <= accept && (|flags_next);
      if (accept) pc_o <= ppc;
    end
  end

  // R10: a request only follows an accepted report
  p_req_src_r10: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $past(accept));

  // R11: the faulting address moves only on an accepted report
  p_pc_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(pc_o));
endmodule

// File: rtl/fpflag_accum.sv
module fpflag_accum
  import fpflag_pkg::*;
#(
  parameter int CSR_W = 12,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  input  logic             st_valid,
  input  logic [NST-1:0]   st_bits,
  input  logic [PC_W-1:0]  st_ppc,
  output logic [CSR_W-1:0] csr_q,
  output logic             fpe_req,
  output logic [PC_W-1:0]  fpe_pc
);
  logic [NFLAG-1:0] set;
  logic [NFLAG-1:0] flags_next;
  logic             accept;

  assign accept = st_valid && !csr_we && csr_q[CSR_EN];

  fpflag_map u_map (
    .st_i  (st_bits),
    .set_o (set)
  );

  fpflag_csr #(.CSR_W(CSR_W)) u_csr (
    .clk        (clk),
    .rst        (rst),
    .we         (csr_we),
    .wdata      (csr_wdata),
    .accept     (accept),
    .set        (set),
    .csr_q      (csr_q),
    .flags_next (flags_next)
  );

  fpflag_exc #(.PC_W(PC_W)) u_exc (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .flags_next (flags_next),
    .ppc        (st_ppc),
    .req_o      (fpe_req),
    .pc_o       (fpe_pc)
  );

  // R3: a write colliding with a report suppresses the request
  p_wr_prio_r3: assert property (@(posedge clk) disable iff (rst)
    (csr_we && st_valid) |=> !fpe_req);

  // R4: a report with enable clear changes nothing
  p_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !csr_we && !csr_q[CSR_EN]) |=> ($stable(csr_q) && !fpe_req));

  // R8: without inf causes the infinity flag stays clear
  p_inf_r8: assert property (@(posedge clk) disable iff (rst)
    (!csr_we && !csr_q[CSR_INF] && !st_bits[ST_ISI] && !st_bits[ST_IDI])
      |=> !csr_q[CSR_INF]);

  // R10: a request implies at least one flag is set
  p_req_flags_r10: assert property (@(posedge clk) disable iff (rst)
    fpe_req |-> (csr_q[FLAG_LO +: NFLAG] != '0));
endmodule

// File: tb/fpflag_accum_tb.sv
module fpflag_accum_tb;
  localparam int CSR_W = 12;
  localparam int PC_W  = 16;

  logic             clk = 1'b0;
  logic             rst;
  logic             csr_we;
  logic [CSR_W-1:0] csr_wdata;
  logic             st_valid;
  logic [12:0]      st_bits;
  logic [PC_W-1:0]  st_ppc;
  logic [CSR_W-1:0] csr_q;
  logic             fpe_req;
  logic [PC_W-1:0]  fpe_pc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fpflag_accum #(.CSR_W(CSR_W), .PC_W(PC_W)) u_dut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .st_valid(st_valid), .st_bits(st_bits), .st_ppc(st_ppc),
    .csr_q(csr_q), .fpe_req(fpe_req), .fpe_pc(fpe_pc)
  );

  function automatic logic [7:0] exp_flags(input logic [12:0] p);
    logic ivf, snf, qnf, ovf, unf, inf, dz, ix;
    ivf = |p[8:0];
    snf = p[0];
    qnf = p[1];
    ovf = p[9];
    unf = p[10];
    inf = p[2] | p[3];
    dz  = p[11];
    ix  = p[12];
    return {ix, dz, inf, unf, ovf, qnf, snf, ivf};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // called at a falling edge; applies inputs for one rising edge
  task automatic step(input logic we, input logic [CSR_W-1:0] wd,
                      input logic sv, input logic [12:0] st, input logic [PC_W-1:0] pc);
    csr_we = we; csr_wdata = wd; st_valid = sv; st_bits = st; st_ppc = pc;
    @(posedge clk);
    @(negedge clk);
    csr_we = 1'b0; st_valid = 1'b0; st_bits = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    logic [CSR_W-1:0] wd;
    logic [CSR_W-1:0] acc;
    logic [7:0]       ef;
    logic [PC_W-1:0]  pc;
    rst = 1'b1; csr_we = 1'b0; csr_wdata = '0; st_valid = 1'b0; st_bits = '0; st_ppc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 csr after reset", 32'(csr_q), 0);
    chk("R1 req after reset", 32'(fpe_req), 0);
    chk("R1 pc after reset", 32'(fpe_pc), 0);

    // enabled sweep over every status pattern
    for (int p = 0; p < 8192; p++) begin
      wd = CSR_W'((p & 7) << 9) | CSR_W'(1);
      step(1'b1, wd, 1'b0, '0, '0);
      chk("R2 write", 32'(csr_q), 32'(wd));
      ef = exp_flags(13'(p));
      pc = PC_W'(p * 3 + 16'h1000);
      step(1'b0, '0, 1'b1, 13'(p), pc);
      chk("R5 R6 R7 R8 R9 flag map", 32'(csr_q), 32'(wd | (CSR_W'(ef) << 1)));
      chk("R10 request", 32'(fpe_req), 32'(ef != 0));
      if (ef != 0) chk("R11 pc", 32'(fpe_pc), 32'(pc));
      step(1'b0, '0, 1'b0, '0, '0);
      chk("R10 pulse ends", 32'(fpe_req), 0);
      chk("R9 hold", 32'(csr_q), 32'(wd | (CSR_W'(ef) << 1)));
    end

    // disabled sweep: register seeded with flags but enable clear
    for (int p = 0; p < 8192; p++) begin
      wd = CSR_W'((p & 7) << 9) | CSR_W'(((p >> 3) & 8'hff) << 1);
      step(1'b1, wd, 1'b0, '0, '0);
      step(1'b0, '0, 1'b1, 13'(p), 16'hbeef);
      chk("R4 csr unchanged", 32'(csr_q), 32'(wd));
      chk("R4 no request", 32'(fpe_req), 0);
    end

    // stale flag triggers request on an empty report
    step(1'b1, CSR_W'(12'h011), 1'b0, '0, '0);
    step(1'b0, '0, 1'b1, '0, 16'h2222);
    chk("R10 stale flag request", 32'(fpe_req), 1);
    chk("R11 stale pc", 32'(fpe_pc), 32'h2222);
    chk("R9 stale csr", 32'(csr_q), 32'h011);
    step(1'b1, CSR_W'(12'h001), 1'b0, '0, '0);
    chk("R2 clear flags", 32'(csr_q), 32'h001);
    step(1'b0, '0, 1'b1, '0, 16'h3333);
    chk("R10 no flags no request", 32'(fpe_req), 0);

    // write collides with report
    step(1'b0, '0, 1'b0, '0, '0);
    step(1'b1, CSR_W'(12'h601), 1'b1, 13'h1fff, 16'h4444);
    chk("R3 write wins", 32'(csr_q), 32'h601);
    chk("R3 no request", 32'(fpe_req), 0);

    // accumulation of single causes
    step(1'b1, CSR_W'(12'h001), 1'b0, '0, '0);
    acc = CSR_W'(12'h001);
    for (int k = 0; k < 13; k++) begin
      acc = acc | (CSR_W'(exp_flags(13'(1 << k))) << 1);
      step(1'b0, '0, 1'b1, 13'(1 << k), PC_W'(k));
      chk("R9 accumulate", 32'(csr_q), 32'(acc));
      chk("R10 accumulate request", 32'(fpe_req), 1);
      chk("R11 accumulate pc", 32'(fpe_pc), 32'(k));
    end

    report();
  end
endmodule